// File: doc/BRIEF.md
# Adaptive Jacobi Sweep Sequencer

This block schedules the column pairs of a one-sided Jacobi orthogonalization over a linear array of processing units. Each sweep runs in rounds. In a round, unit `u` owns the pivot column `base+u`. A shared partner index `j` then steps upward through the remaining columns. At each step, every unit whose pivot is below `j` receives the pair (pivot, j). The step holds until every unit that was offered a pair has acknowledged it. Only then does the sequencer move on, so units that take different times per pair stay in lock step.

Each acknowledgement carries two flags. One says the partner column was found to have a null norm. The other says a rotation was applied. The sequencer keeps the smallest partner index reported as null. At the end of the sweep, that index becomes the active column count for the next sweep, so the problem shrinks online to the estimated rank. A sweep in which no unit rotated ends the run with a converged pulse. A sweep that leaves fewer than two active columns also ends the run.

Top module: `jacobi_sweep_seq`

## Requirements
- R1: After reset, `busy`, `sweep_done`, `converged` and every `pair_valid` bit are 0, and `act_cols` is 0.
- R2: A `start` pulse while idle loads `act_cols` with `n_cols`, clipped to `MAX_COLS`. A `start` pulse or a change of `n_cols` while busy has no effect on the schedule or on `act_cols`.
- R3: A sweep is a series of rounds with `base` = 0, NUM_PU, 2·NUM_PU, …, continuing while `base` ≤ act_cols−2. Within a round, `j` runs from base+1 to act_cols−1, one step per completed step. Unit `u` presents `pair_i`=base+u and `pair_j`=j exactly when base+u ≤ act_cols−2 and j > base+u.
- R4: A unit with no pair in the current step holds `pair_valid` low and drives 0 on `pair_i` and `pair_j`. In the last round, surplus units get no pairs.
- R5: A step advances only after every unit that was offered a pair has asserted `res_valid` while its own `pair_valid` was high. A unit that is already acknowledged drops `pair_valid`, while the others hold their pairs unchanged.
- R6: `res_valid` on a unit whose `pair_valid` is low is ignored, together with that unit's flags.
- R7: The smallest `pair_j` acknowledged with `res_null`=1 during a sweep becomes `act_cols` from the cycle after `sweep_done`. If the sweep reports no null column, `act_cols` is unchanged. `act_cols` never increases while busy.
- R8: After the final step of a sweep, `sweep_done` is high for exactly one cycle, with `act_cols` still showing the old count. `converged` is high in that same cycle iff no acknowledgement in the sweep carried `res_rot`=1, or the new count is below 2. When `converged` is high the block goes idle; otherwise the next sweep's first step appears in the following cycle.
- R9: A `start` with a clipped count below 2 produces no pairs. The next cycle carries `sweep_done` and `converged`.
- R10: The number of rounds in a sweep never exceeds 1 + floor(act_cols / NUM_PU).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled while idle) |
| n_cols | input | CW | Initial column count |
| res_valid | input | NUM_PU | Per-unit acknowledgement of the presented pair |
| res_null | input | NUM_PU | Partner column of the pair has a null norm |
| res_rot | input | NUM_PU | The pair was rotated |
| pair_valid | output | NUM_PU | Unit holds a pair to process |
| pair_i | output | NUM_PU×CW | Pivot index per unit |
| pair_j | output | NUM_PU×CW | Partner index per unit |
| sweep_done | output | 1 | One-cycle end-of-sweep pulse |
| converged | output | 1 | Run finished, with `sweep_done` |
| busy | output | 1 | A run is in progress |
| act_cols | output | CW | Active column count |

## Verification
The hardest situation to reach from the ports is a step that is only partly acknowledged. In that state some units have dropped `pair_valid` and others still hold their pair, and stray acknowledgements on idle units must not disturb the null-index or rotation records. The responder in the bench has a mode that acknowledges one unit per cycle, lowest first. Another mode drives `res_valid` with both flags set on every unit that holds no pair. A further run starts with more columns than the block supports and with a low rank, so the count is clipped and then shrinks after the first sweep. A final run drops straight to one column, which ends the run even though rotations were reported.

// File: rtl/sweep_seq_pkg.sv
package sweep_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WRAP  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pair_lane.sv
// One unit's view of the current step: pivot = base + LANE, partner = shared j.
module pair_lane #(
  parameter int CW   = 5,
  parameter int LANE = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_i,
  input  logic          step_clear_i,
  input  logic [CW-1:0] base_i,
  input  logic [CW-1:0] jcur_i,
  input  logic [CW-1:0] act_i,
  input  logic          ack_i,
  output logic          vld_o,
  output logic [CW-1:0] i_o,
  output logic [CW-1:0] j_o,
  output logic          pend_o
);
  localparam int XW = CW + 1;
  localparam logic [XW-1:0] OFF = XW'(LANE);

  logic [XW-1:0] piv_x;
  logic          live;
  logic          done_q, done_n, done_en;

  always_comb begin
    piv_x  = {1'b0, base_i} + OFF;
    live   = issue_i && ((piv_x + XW'(2)) <= {1'b0, act_i})
                     && ({1'b0, jcur_i} > piv_x);
    vld_o  = live && !done_q;
    pend_o = vld_o && !ack_i;
    i_o    = vld_o ? piv_x[CW-1:0] : '0;
    j_o    = vld_o ? jcur_i : '0;
    done_en = step_clear_i || (vld_o && ack_i);
    done_n  = step_clear_i ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       done_q <= 1'b0;
    else if (done_en) done_q <= done_n;
  end

  // R5: an unacknowledged pair stays presented and unchanged
  a_r5_hold_pair: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o |=> (vld_o && $stable(i_o) && $stable(j_o)));

  // R3: partner always above pivot
  a_r3_j_above_i: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (j_o > i_o));
endmodule

// File: rtl/rank_tracker.sv
// Holds the active column count, the smallest null index and the rotation flag.
module rank_tracker #(
  parameter int CW     = 5,
  parameter int NUM_PU = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CW-1:0]     load_cols_i,
  input  logic              wrap_i,
  input  logic [NUM_PU-1:0] acc_i,
  input  logic [NUM_PU-1:0] null_i,
  input  logic [NUM_PU-1:0] rot_i,
  input  logic [CW-1:0]     jcur_i,
  output logic [CW-1:0]     act_o,
  output logic [CW-1:0]     ns_o,
  output logic              dirty_o
);
  logic [CW-1:0] act_q, act_n, ns_q, ns_n;
  logic          dirty_q, dirty_n;
  logic          hit_null, hit_rot, trk_en;

  always_comb begin
    hit_null = |(acc_i & null_i);
    hit_rot  = |(acc_i & rot_i);
    act_n    = act_q;
    ns_n     = ns_q;
    dirty_n  = dirty_q;
    if (load_i) begin
      act_n   = load_cols_i;
      ns_n    = load_cols_i;
      dirty_n = 1'b0;
    end else if (wrap_i) begin
      act_n   = ns_q;
      dirty_n = 1'b0;
    end else begin
      if (hit_null && (jcur_i < ns_q)) ns_n = jcur_i;
      if (hit_rot)                     dirty_n = 1'b1;
    end
    trk_en = load_i || wrap_i || hit_null || hit_rot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= '0;
      ns_q    <= '0;
      dirty_q <= 1'b0;
    end else if (trk_en) begin
      act_q   <= act_n;
      ns_q    <= ns_n;
      dirty_q <= dirty_n;
    end
  end

  assign act_o   = act_q;
  assign ns_o    = ns_q;
  assign dirty_o = dirty_q;

  // R7: the count only shrinks unless a new run is loaded
  a_r7_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (act_q <= $past(act_q)));

  // R7: the null index never exceeds the active count
  a_r7_ns_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ns_q <= act_q);
endmodule

// File: rtl/sweep_ctrl.sv
// Round / step sequencing for one sweep and the sweep-to-sweep decision.
module sweep_ctrl
  import sweep_seq_pkg::*;
#(
  parameter int MAX_COLS = 16,
  parameter int NUM_PU   = 3,
  parameter int CW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] n_cols_i,
  input  logic          step_clear_i,
  input  logic [CW-1:0] act_i,
  input  logic [CW-1:0] ns_i,
  input  logic          dirty_i,
  output seq_state_e    state_o,
  output logic [CW-1:0] base_o,
  output logic [CW-1:0] jcur_o,
  output logic          load_o,
  output logic [CW-1:0] load_cols_o,
  output logic          wrap_o,
  output logic          conv_o
);
  localparam int XW = CW + 1;
  localparam logic [XW-1:0] PU_X  = XW'(NUM_PU);
  localparam logic [CW-1:0] MAX_C = CW'(MAX_COLS);

  seq_state_e    st_q, st_n;
  logic [CW-1:0] base_q, base_n, j_q, j_n;
  logic [CW-1:0] clip;
  logic          conv, seq_en;

  always_comb begin
    clip   = (n_cols_i > MAX_C) ? MAX_C : n_cols_i;
    conv   = !dirty_i || (ns_i < CW'(2));
    st_n   = st_q;
    base_n = base_q;
    j_n    = j_q;
    load_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o = 1'b1;
          base_n = '0;
          j_n    = CW'(1);
          st_n   = (clip < CW'(2)) ? ST_WRAP : ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (step_clear_i) begin
          if (({1'b0, j_q} + XW'(1)) == {1'b0, act_i}) begin
            if (({1'b0, base_q} + PU_X + XW'(2)) <= {1'b0, act_i}) begin
              base_n = base_q + CW'(NUM_PU);
              j_n    = base_q + CW'(NUM_PU + 1);
            end else begin
              st_n = ST_WRAP;
            end
          end else begin
            j_n = j_q + CW'(1);
          end
        end
      end
      ST_WRAP: begin
        base_n = '0;
        j_n    = CW'(1);
        st_n   = conv ? ST_IDLE : ST_ISSUE;
      end
      default: st_n = ST_IDLE;
    endcase
    seq_en = load_o || step_clear_i || (st_q == ST_WRAP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      base_q <= '0;
      j_q    <= '0;
    end else if (seq_en) begin
      st_q   <= st_n;
      base_q <= base_n;
      j_q    <= j_n;
    end
  end

  assign state_o     = st_q;
  assign base_o      = base_q;
  assign jcur_o      = j_q;
  assign load_cols_o = clip;
  assign wrap_o      = (st_q == ST_WRAP);
  assign conv_o      = (st_q == ST_WRAP) && conv;

  // R3: the partner index stays inside the round's window
  a_r3_j_window: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ISSUE) |-> ((j_q > base_q) && (j_q < act_i)));

  // R8: end-of-sweep is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WRAP) |=> (st_q != ST_WRAP));

  // R9: a degenerate count goes straight to the end of sweep
  a_r9_tiny_run: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && start_i && (clip < CW'(2))) |=> (st_q == ST_WRAP));

  // R10: round index bounded by floor(act/NUM_PU)
  a_r10_round_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ISSUE) |-> (({1'b0, base_q} / PU_X) <= ({1'b0, act_i} / PU_X)));
endmodule

// File: rtl/jacobi_sweep_seq.sv
module jacobi_sweep_seq
  import sweep_seq_pkg::*;
#(
  parameter int MAX_COLS = 16,
  parameter int NUM_PU   = 3,
  parameter int CW       = $clog2(MAX_COLS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [CW-1:0]              n_cols,
  input  logic [NUM_PU-1:0]          res_valid,
  input  logic [NUM_PU-1:0]          res_null,
  input  logic [NUM_PU-1:0]          res_rot,
  output logic [NUM_PU-1:0]          pair_valid,
  output logic [NUM_PU-1:0][CW-1:0]  pair_i,
  output logic [NUM_PU-1:0][CW-1:0]  pair_j,
  output logic                       sweep_done,
  output logic                       converged,
  output logic                       busy,
  output logic [CW-1:0]              act_cols
);
  seq_state_e        st;
  logic [CW-1:0]     base, jcur, act, ns, load_cols;
  logic              load, wrap, conv, dirty, step_clear, issue;
  logic [NUM_PU-1:0] pend, acc;

  assign issue      = (st == ST_ISSUE);
  assign step_clear = issue && (pend == '0);
  assign acc        = pair_valid & res_valid;

  sweep_ctrl #(.MAX_COLS(MAX_COLS), .NUM_PU(NUM_PU), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .n_cols_i(n_cols),
    .step_clear_i(step_clear), .act_i(act), .ns_i(ns), .dirty_i(dirty),
    .state_o(st), .base_o(base), .jcur_o(jcur), .load_o(load),
    .load_cols_o(load_cols), .wrap_o(wrap), .conv_o(conv)
  );

  rank_tracker #(.CW(CW), .NUM_PU(NUM_PU)) u_track (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_cols_i(load_cols),
    .wrap_i(wrap), .acc_i(acc), .null_i(res_null), .rot_i(res_rot),
    .jcur_i(jcur), .act_o(act), .ns_o(ns), .dirty_o(dirty)
  );

  for (genvar u = 0; u < NUM_PU; u++) begin : g_lane
    pair_lane #(.CW(CW), .LANE(u)) u_lane (
      .clk(clk), .rst_n(rst_n), .issue_i(issue), .step_clear_i(step_clear),
      .base_i(base), .jcur_i(jcur), .act_i(act), .ack_i(res_valid[u]),
      .vld_o(pair_valid[u]), .i_o(pair_i[u]), .j_o(pair_j[u]),
      .pend_o(pend[u])
    );
  end

  assign sweep_done = wrap;
  assign converged  = conv;
  assign busy       = (st != ST_IDLE);
  assign act_cols   = act;

  // R4: no pairs outside the issue phase
  a_r4_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |-> (pair_valid == '0));

  // R8: converged only accompanies end of sweep
  a_r8_conv_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    converged |-> sweep_done);
endmodule

// File: tb/jacobi_sweep_seq_tb.sv
module jacobi_sweep_seq_tb;
  localparam int P  = 3;
  localparam int MC = 16;
  localparam int W  = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [W-1:0]      n_cols = '0;
  logic [P-1:0]      res_valid = '0, res_null = '0, res_rot = '0;
  logic [P-1:0]      pair_valid;
  logic [P-1:0][W-1:0] pair_i, pair_j;
  logic              sweep_done, converged, busy;
  logic [W-1:0]      act_cols;

  jacobi_sweep_seq #(.MAX_COLS(MC), .NUM_PU(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .n_cols(n_cols),
    .res_valid(res_valid), .res_null(res_null), .res_rot(res_rot),
    .pair_valid(pair_valid), .pair_i(pair_i), .pair_j(pair_j),
    .sweep_done(sweep_done), .converged(converged), .busy(busy),
    .act_cols(act_cols)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    bit                  is_end;
    logic [P-1:0]        mask;
    logic [P-1:0][W-1:0] iv;
    logic [P-1:0][W-1:0] jv;
    bit                  conv;
    int                  act;
  } exp_t;

  exp_t q[$];
  int   total = 0, bad = 0;
  bit   finished = 0;

  // case controls shared with the monitor
  int   c_rank = 0, c_rot = 0;
  bit   c_split = 0, c_noise = 0, case_done = 0, mon_on = 0;
  int   sweep_idx = 0, rounds = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: build the expected schedule, then launch the run
  task automatic run_case(input int n, input int rank, input int rot,
                          input bit split, input bit noise, input bit poke);
    int   act, newact, s;
    bit   dirty, nul, conv;
    exp_t e;
    act = (n > MC) ? MC : n;
    s = 0;
    newact = act;
    forever begin
      if (act >= 2) begin
        for (int b = 0; b <= act - 2; b += P) begin
          for (int j = b + 1; j <= act - 1; j++) begin
            e = '{default: '0};
            for (int u = 0; u < P; u++) begin
              if ((b + u <= act - 2) && (j > b + u)) begin
                e.mask[u] = 1'b1;
                e.iv[u]   = W'(b + u);
                e.jv[u]   = W'(j);
              end
            end
            q.push_back(e);
          end
        end
      end
      dirty  = (act >= 2) && (s < rot);
      nul    = (act >= 2) && (rank < act);
      newact = nul ? rank : act;
      conv   = !dirty || (newact < 2);
      e = '{default: '0};
      e.is_end = 1'b1;
      e.conv   = conv;
      e.act    = act;
      q.push_back(e);
      if (conv) break;
      act = newact;
      s++;
    end
    c_rank = rank; c_rot = rot; c_split = split; c_noise = noise;
    case_done = 0; sweep_idx = 0; rounds = 0;
    @(negedge clk);
    n_cols = W'(n);
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      n_cols = W'(2);
      start  = 1'b1;                  // R2: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    wait (case_done);
    @(posedge clk);
    #1;
    chk(busy == 1'b0, "R8", "idle after converged", busy, 0);
    chk(act_cols == W'(newact), "R7", "final active count", act_cols, newact);
    chk(q.size() == 0, "R3", "schedule fully issued", q.size(), 0);
  endtask

  // monitor / scoreboard with a responder acting as the unit array
  initial begin
    bit           fresh = 1;
    logic [P-1:0] rem = '0, resp;
    exp_t         cur = '{default: '0};
    exp_t         e;
    forever begin
      @(negedge clk);
      res_valid = '0; res_null = '0; res_rot = '0;
      if (mon_on) begin
        resp = '0;
        if (fresh) begin
          if ((pair_valid != '0) || sweep_done) begin
            if (q.size() == 0) begin
              chk(0, "R3", "unexpected output", int'(pair_valid), 0);
            end else begin
              e = q.pop_front();
              if (e.is_end) begin
                chk(sweep_done == 1'b1, "R8", "sweep_done", sweep_done, 1);
                chk(converged == e.conv, "R8", "converged", converged, e.conv);
                chk(act_cols == W'(e.act), "R7", "count during end", act_cols, e.act);
                chk(pair_valid == '0, "R4", "no pairs at end", pair_valid, 0);
                chk(rounds <= 1 + e.act / P, "R10", "rounds per sweep", rounds, 1 + e.act / P);
                sweep_idx++;
                rounds = 0;
                if (e.conv) case_done = 1;
              end else begin
                chk(sweep_done == 1'b0, "R8", "no done mid sweep", sweep_done, 0);
                chk(pair_valid == e.mask, "R3", "valid mask", pair_valid, e.mask);
                for (int u = 0; u < P; u++) begin
                  if (e.mask[u]) begin
                    chk(pair_i[u] == e.iv[u], "R3", "pivot", pair_i[u], e.iv[u]);
                    chk(pair_j[u] == e.jv[u], "R3", "partner", pair_j[u], e.jv[u]);
                  end else begin
                    chk((pair_i[u] == '0) && (pair_j[u] == '0), "R4",
                        "idle unit zero", pair_j[u], 0);
                  end
                end
                if (e.mask[0] && (e.jv[0] == e.iv[0] + 1)) rounds++;
                cur = e;
                rem = e.mask;
              end
            end
          end
        end else begin
          chk(pair_valid == rem, "R5", "partial ack mask", pair_valid, rem);
          for (int u = 0; u < P; u++)
            if (rem[u])
              chk(pair_j[u] == cur.jv[u], "R5", "held partner", pair_j[u], cur.jv[u]);
        end
        if (rem != '0) begin
          resp = c_split ? (rem & (~rem + 1'b1)) : rem;
          for (int u = 0; u < P; u++) begin
            if (resp[u]) begin
              res_null[u] = (int'(cur.jv[u]) >= c_rank);
              res_rot[u]  = (sweep_idx < c_rot);
            end else begin
              res_null[u] = 1'b1;     // R6: garbage on idle units
              res_rot[u]  = 1'b1;
            end
          end
          res_valid = resp | (c_noise ? ~pair_valid : '0);
          rem   = rem & ~resp;
        end
        fresh = (rem == '0);
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(pair_valid == '0, "R1", "pair_valid", pair_valid, 0);
    chk(sweep_done == 1'b0, "R1", "sweep_done", sweep_done, 0);
    chk(converged == 1'b0, "R1", "converged", converged, 0);
    chk(act_cols == '0, "R1", "act_cols", act_cols, 0);
    mon_on = 1;
    run_case(8, 8, 2, 0, 0, 0);    // R3 full rank, three sweeps
    run_case(9, 5, 3, 1, 0, 1);    // R5 split acks, R7 shrink, R2 poke
    run_case(7, 7, 0, 0, 1, 0);    // R6 noise, converge at once
    run_case(1, 1, 0, 0, 0, 0);    // R9 degenerate
    run_case(20, 3, 1, 0, 1, 0);   // R2 clip to MAX_COLS, R7 shrink
    run_case(6, 1, 5, 1, 0, 0);    // R8 count below 2 ends run
    run_case(5, 5, 1, 0, 0, 0);    // R4 surplus units in last round
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule